// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This engine runs one serial flash transaction for each request it accepts. A higher-level controller picks the command. It hands over an opcode, an optional 32-bit address, a dummy-clock count, a lane width, a data direction and, for programming, a byte count. The sequencer then lowers chip select and clocks the phases out in turn: the opcode, the address, the dummy clocks and the data. When the transaction ends it raises chip select again.

Read data is returned one byte at a time over a valid/ready pair. Write data is pulled one byte at a time over another. At each byte boundary the serial clock waits for the handshake, so neither side needs a buffer. A read has no length. It runs until the requester raises a stop input while accepting a byte. A program transaction carries between 1 and 256 bytes, and any other count is refused with an error pulse. A per-request slow select doubles the serial clock period for the plain read command, which is limited to half the rate of the other commands.

Top module: `sflash_seq`

## Requirements
- R1: Each accepted request lowers `cs_n` and shifts the opcode out on io0 alone (`io_oe`=0001), most significant bit first, over 8 serial clocks. `sck` idles low, outputs change only when `sck` falls, and inputs are sampled when `sck` rises.
- R2: When `req_has_addr` is set, 32 address bits follow the opcode, most significant bit first. The lane code `req_lanes` selects the lanes: 00 uses io0 (32 clocks), 01 uses io[1:0] (16 clocks) and 1x uses io[3:0] (8 clocks). The higher-numbered lane carries the more significant bit, and every lane in use is enabled.
- R3: `req_dummy` serial clocks follow the address, or the opcode when there is no address. During these clocks `io_oe` is 0000 in two- and four-lane modes. In single-lane mode io0 stays enabled and driven low.
- R4: With `req_kind`=01 (read), data is sampled on the rising edge, most significant bit first. It comes from io1 in single-lane mode, from io[1:0] in two-lane mode and from io[3:0] in four-lane mode, with `io_oe` as in R3. Each byte is offered on `rd_data` with `rd_valid`, and it stays unchanged until `rd_ready`. The serial clock pauses before the next byte while a byte is waiting.
- R5: A read returns at least one byte, even if `rd_stop` is already high. It ends only when `rd_stop` is high at the moment a returned byte is accepted, so the byte count equals the number of bytes accepted up to that point.
- R6: With `req_kind`=10 (write), exactly `req_len` bytes are taken through `wr_valid`/`wr_ready`. They are shifted out most significant bit first on the lanes chosen by `req_lanes`, with those lanes enabled.
- R7: A write request whose `req_len` is 0 or above 256 is consumed with a one-cycle `err` pulse. `cs_n` stays high and `sck` does not toggle.
- R8: With `req_kind`=00 or 11 there is no data phase. `cs_n` rises after the last opcode, address or dummy clock.
- R9: With `req_slow` clear, each high and each low half of `sck` lasts one system clock. With it set, each half lasts two.
- R10: `cs_n` stays high for at least 2 system clocks between transactions. `done` pulses once per transaction. `busy` is high from acceptance until the sequencer can take a new request, and `req_ready` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_opcode | input | 8 | Command byte |
| req_has_addr | input | 1 | Send a 32-bit address after the opcode |
| req_addr | input | 32 | Address |
| req_dummy | input | 5 | Number of dummy clocks |
| req_lanes | input | 2 | Lane width for address and data: 00 one, 01 two, 1x four |
| req_kind | input | 2 | 01 read, 10 write, 00/11 no data |
| req_len | input | 9 | Write byte count (1 to 256) |
| req_slow | input | 1 | Double the serial clock period |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle if valid |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte accepted |
| rd_stop | input | 1 | End the read when the current byte is accepted |
| busy | output | 1 | Transaction or chip-select gap in progress |
| done | output | 1 | One-cycle pulse when chip select rises |
| err | output | 1 | One-cycle pulse for a refused write request |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The bench compares every lane sample at every rising `sck` edge in every phase. It does this for a no-data command, an erase with a single-lane address, slow plain reads, and fast reads with 8 and 10 dummy clocks in one-, two- and four-lane modes. An error in address lane packing, dummy length or output-enable release would show up there as a wrong sample or an extra or missing edge. Reads are consumed with a delay and stopped at chosen byte counts. One read holds `rd_stop` high from the start, so a sequencer that dropped the first byte, ran on past the stop or ignored backpressure would return the wrong bytes or the wrong count. Writes of 2, 3 and 256 bytes and refused lengths of 0 and 257 test the length limits, where an off-by-one would clock out the wrong number of bytes or start a transaction it should refuse.

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int MAXLEN = 256,
  parameter int GAP = 2,
  localparam int LW = $clog2(MAXLEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [7:0]    req_opcode,
  input  logic          req_has_addr,
  input  logic [31:0]   req_addr,
  input  logic [4:0]    req_dummy,
  input  logic [1:0]    req_lanes,
  input  logic [1:0]    req_kind,
  input  logic [LW-1:0] req_len,
  input  logic          req_slow,
  input  logic [7:0]    wr_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  input  logic          rd_stop,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          sck,
  output logic          cs_n,
  output logic [3:0]    io_out,
  output logic [3:0]    io_oe,
  input  logic [3:0]    io_in
);
  localparam int GW = $clog2(GAP + 1);
  typedef enum logic [2:0] {IDLE, CMD, ADDR, DUMMY, DATA, GAPS} ph_t;

  ph_t ph, nxt;
  logic [31:0] sr, adr;
  logic [7:0] rx;
  logic [5:0] cnt;
  logic [2:0] bstep;
  logic [LW-1:0] blen;
  logic [1:0] lsh, kind;
  logic [4:0] dum;
  logic [GW-1:0] gcnt;
  logic has_a, slow, hcnt, need, got;

  wire wr = kind == 2'b10;
  wire rd = kind == 2'b01;
  wire active = ph inside {CMD, ADDR, DUMMY, DATA};
  wire [2:0] spb1 = 3'((8 >> lsh) - 1);
  wire [1:0] wsh = (ph == CMD) ? 2'd0 : lsh;
  wire [2:0] sw = 3'(1 << wsh);
  wire [3:0] lmask = (lsh == 2'd0) ? 4'b0001 : (lsh == 2'd1) ? 4'b0011 : 4'b1111;
  wire [7:0] rx_n = (lsh == 2'd0) ? {rx[6:0], io_in[1]} :
                    (lsh == 2'd1) ? {rx[5:0], io_in[1:0]} : {rx[3:0], io_in};

  wire bnd   = ph == DATA && rd && got && !sck && !hcnt && bstep == spb1;
  wire stall = need || (bnd && rd_valid && !rd_ready);
  wire stop  = bnd && !stall && rd_stop;
  wire tick  = hcnt == slow;
  wire adv   = active && !stall && !stop;
  wire rise  = adv && tick && !sck;
  wire fall  = adv && tick && sck;
  wire fin   = stop || (fall && ((ph == DATA && wr && bstep == 3'd0 && blen == LW'(1)) ||
                                 (ph != DATA && cnt == 6'd0 && nxt == GAPS)));

  assign req_ready = ph == IDLE;
  assign busy = ph != IDLE;
  assign wr_ready = need;
  assign io_out = cs_n ? 4'b0000 :
                  (wsh == 2'd0) ? {3'b000, sr[31]} :
                  (wsh == 2'd1) ? {2'b00, sr[31:30]} : sr[31:28];

  always_comb begin
    if (cs_n) io_oe = 4'b0000;
    else if (ph == CMD) io_oe = 4'b0001;
    else if (ph == ADDR || (ph == DATA && wr)) io_oe = lmask;
    else io_oe = (lsh == 2'd0) ? 4'b0001 : 4'b0000;
  end

  always_comb begin
    nxt = GAPS;
    if (ph == CMD && has_a) nxt = ADDR;
    else if ((ph == CMD || ph == ADDR) && dum != 5'd0) nxt = DUMMY;
    else if (ph != DATA && (rd || wr)) nxt = DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= IDLE; sr <= '0; adr <= '0; rx <= '0; cnt <= '0; bstep <= '0; blen <= '0;
      lsh <= '0; kind <= '0; dum <= '0; gcnt <= '0; has_a <= 1'b0; slow <= 1'b0;
      hcnt <= 1'b0; need <= 1'b0; got <= 1'b0; sck <= 1'b0; cs_n <= 1'b1;
      rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (need && wr_valid) begin
        sr <= {wr_data, 24'd0};
        need <= 1'b0;
      end
      if (adv) hcnt <= tick ? 1'b0 : 1'b1;
      case (ph)
        IDLE: if (req_valid) begin
          if (req_kind == 2'b10 && (req_len == '0 || int'(req_len) > MAXLEN)) err <= 1'b1;
          else begin
            ph <= CMD; cs_n <= 1'b0; sr <= {req_opcode, 24'd0}; cnt <= 6'd7; hcnt <= 1'b0;
            adr <= req_addr; has_a <= req_has_addr; dum <= req_dummy; kind <= req_kind;
            blen <= req_len; slow <= req_slow;
            lsh <= (req_lanes == 2'b00) ? 2'd0 : (req_lanes == 2'b01) ? 2'd1 : 2'd2;
          end
        end
        GAPS: if (gcnt == '0) ph <= IDLE; else gcnt <= gcnt - 1'b1;
        default:
          if (fin) begin
            cs_n <= 1'b1; sck <= 1'b0; ph <= GAPS; gcnt <= GW'(GAP - 1); done <= 1'b1;
          end else if (rise) begin
            sck <= 1'b1;
            if (ph == DATA && rd) rx <= rx_n;
          end else if (fall) begin
            sck <= 1'b0;
            if (ph == DATA) begin
              sr <= sr << sw;
              if (bstep != 3'd0) bstep <= bstep - 3'd1;
              else begin
                bstep <= spb1;
                if (wr) begin
                  blen <= blen - 1'b1;
                  need <= 1'b1;
                end else begin
                  rd_data <= rx; rd_valid <= 1'b1; got <= 1'b1;
                end
              end
            end else if (cnt != 6'd0) begin
              sr <= sr << sw;
              cnt <= cnt - 6'd1;
            end else begin
              ph <= nxt;
              case (nxt)
                ADDR:  begin sr <= adr; cnt <= 6'((32 >> lsh) - 1); end
                DUMMY: begin sr <= '0; cnt <= 6'(dum) - 6'd1; end
                default: begin sr <= '0; bstep <= spb1; need <= wr; got <= 1'b0; end
              endcase
            end
          end
      endcase
    end
  end

  a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n);
  a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  a_r1_out_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(io_out));
  a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  a_r6_clock_waits_for_wr: assert property (@(posedge clk) disable iff (!rst_n) wr_ready |-> !sck);
  a_r7_reject_no_cs: assert property (@(posedge clk) disable iff (!rst_n) err |-> cs_n && !busy);
endmodule

// File: tb/sflash_seq_test.sv
`timescale 1ns/1ps
module sflash_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_has_addr = 1'b0, req_slow = 1'b0;
  logic [7:0] req_opcode = '0;
  logic [31:0] req_addr = '0;
  logic [4:0] req_dummy = '0;
  logic [1:0] req_lanes = '0, req_kind = '0;
  logic [8:0] req_len = '0;
  logic [7:0] wr_data;
  logic wr_valid = 1'b1, rd_ready = 1'b0, rd_stop;
  logic [3:0] io_in = '0;
  logic req_ready, wr_ready, rd_valid, busy, done, err, sck, cs_n;
  logic [7:0] rd_data;
  logic [3:0] io_out, io_oe;

  sflash_seq #(.MAXLEN(256), .GAP(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_has_addr(req_has_addr), .req_addr(req_addr),
    .req_dummy(req_dummy), .req_lanes(req_lanes), .req_kind(req_kind), .req_len(req_len),
    .req_slow(req_slow), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_stop(rd_stop),
    .busy(busy), .done(done), .err(err), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  typedef struct { logic [7:0] v; string tag; } smp_t;
  smp_t exp_q[$];
  logic [7:0] rdq[$];
  int checks = 0, fails = 0;
  int dbeg = 0, wl = 1, seed = 0, half_exp = 1;
  int rd_tot = 0, rd_base = 0, rd_target = 0, rd_lag = 0, wr_cnt = 0, wr_base = 0;
  int done_tot = 0;
  logic pre_stop = 1'b0;
  bit ended = 0;

  assign rd_stop = pre_stop || (rd_target > 0 && rd_tot - rd_base >= rd_target);

  function automatic logic [7:0] rbyte(int b); return 8'((b * 29 + seed) ^ 'h5A); endfunction
  function automatic logic [7:0] wbyte(int i); return 8'((i * 7 + seed) ^ 'hC3); endfunction
  function automatic logic [3:0] lmask(int w); return w == 1 ? 4'b0001 : w == 2 ? 4'b0011 : 4'b1111; endfunction
  function automatic logic [3:0] chunk(logic [31:0] val, int nbits, int w, int j);
    return 4'((val >> (nbits - (j + 1) * w)) & ((1 << w) - 1));
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] drive_in(int k);
    int s, b, j, spb;
    logic [3:0] c;
    if (k < dbeg) return 4'b0;
    spb = 8 / wl; s = k - dbeg; b = s / spb; j = s % spb;
    c = chunk({24'd0, rbyte(b)}, 8, wl, j);
    return wl == 1 ? {2'b00, c[0], 1'b0} : c;
  endfunction

  logic sck_q = 1'b0, cs_q = 1'b1;
  int rcnt = 0, hi = 0, cs_hi = 0;
  always @(negedge clk) if (rst_n) begin
    smp_t e;
    if (done) done_tot++;
    if (cs_n) begin rcnt = 0; cs_hi++; end
    else begin
      if (cs_q) begin chk("R10 cs_n high gap at least 2", cs_hi >= 2, 1); cs_hi = 0; end
      if (sck && !sck_q) begin
        if (exp_q.size() == 0) chk("R1 unexpected sck rising edge", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk($sformatf("%s lane sample %0d", e.tag, rcnt), {io_oe, io_out}, e.v);
        end
        rcnt++;
      end
    end
    if (sck) hi++;
    else if (sck_q) begin chk("R9 sck high time", hi, half_exp); hi = 0; end
    if (!sck) io_in = drive_in(rcnt);
    sck_q = sck; cs_q = cs_n;
  end

  int lag_c = 0;
  always @(negedge clk) begin
    if (rd_ready) rd_ready = 1'b0;
    else if (rd_valid) begin
      if (lag_c < rd_lag) lag_c++;
      else begin
        lag_c = 0;
        if (rdq.size() == 0) chk("R5 extra read byte", 1, 0);
        else chk("R4 read byte", rd_data, rdq.pop_front());
        rd_ready = 1'b1;
        rd_tot++;
      end
    end
  end

  bit wr_hs = 0;
  always @(negedge clk) begin
    if (wr_hs) wr_cnt++;
    wr_data = wbyte(wr_cnt - wr_base);
    wr_hs = wr_valid && wr_ready;
  end

  task automatic run(string name, logic [7:0] op, bit ha, logic [31:0] ad, int dum, int ln,
                     int kind, int len, bit slow, int nrd, int lag, bit pst);
    int w;
    w = 1 << ln;
    seed = seed + 17;
    for (int i = 0; i < 8; i++) exp_q.push_back('{{4'b0001, 3'b000, op[7 - i]}, "R1"});
    if (ha) for (int i = 0; i < 32 / w; i++) exp_q.push_back('{{lmask(w), chunk(ad, 32, w, i)}, "R2"});
    for (int i = 0; i < dum; i++) exp_q.push_back('{{(w == 1 ? 4'b0001 : 4'b0000), 4'b0}, "R3"});
    if (kind == 1) for (int b = 0; b < nrd; b++) begin
      rdq.push_back(rbyte(b));
      for (int j = 0; j < 8 / w; j++) exp_q.push_back('{{(w == 1 ? 4'b0001 : 4'b0000), 4'b0}, "R4"});
    end
    if (kind == 2) for (int b = 0; b < len; b++)
      for (int j = 0; j < 8 / w; j++)
        exp_q.push_back('{{lmask(w), chunk({24'd0, wbyte(b)}, 8, w, j)}, "R6"});
    dbeg = 8 + (ha ? 32 / w : 0) + dum; wl = w; half_exp = slow ? 2 : 1;
    rd_base = rd_tot; rd_target = (kind == 1) ? nrd : 0; rd_lag = lag; pre_stop = pst;
    wr_base = wr_cnt; done_tot = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_opcode = op; req_has_addr = ha; req_addr = ad;
    req_dummy = 5'(dum); req_lanes = 2'(ln); req_kind = 2'(kind); req_len = 9'(len); req_slow = slow;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    chk({"R10 done pulses ", name}, done_tot, 1);
    chk({"R1 leftover samples ", name}, exp_q.size(), 0);
    exp_q.delete();
    if (kind == 1) chk({"R5 bytes read ", name}, rd_tot - rd_base, nrd);
    if (kind == 2) chk({"R6 bytes taken ", name}, wr_cnt - wr_base, len);
    if (kind == 0 || kind == 3) chk({"R8 cs_n released ", name}, cs_n, 1);
    rdq.delete();
    rd_target = 0; pre_stop = 1'b0;
  endtask

  task automatic reject(int len);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    done_tot = 0;
    req_valid = 1'b1; req_kind = 2'b10; req_len = 9'(len); req_opcode = 8'h02; req_has_addr = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 err pulse", err, 1);
    chk("R7 cs_n stays high", cs_n, 1);
    repeat (6) @(negedge clk);
    chk("R7 no transaction", {busy, sck, cs_n, 5'(done_tot)}, 8'b0010_0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset cs_n", cs_n, 1);
    chk("R10 reset sck/busy/oe", {sck, busy, io_oe}, 0);
    chk("R10 reset req_ready", req_ready, 1);
    rst_n = 1'b1;
    run("wren", 8'h06, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run("erase", 8'hD8, 1, 32'hA1B2_C3D4, 0, 0, 3, 0, 0, 0, 0, 0);
    run("slow read", 8'h03, 1, 32'h0012_3456, 0, 0, 1, 0, 1, 3, 2, 0);
    run("fast read x1", 8'h0B, 1, 32'hFEDC_BA98, 8, 0, 1, 0, 0, 5, 3, 0);
    run("dual read", 8'hBB, 1, 32'h1357_9BDF, 10, 1, 1, 0, 0, 4, 0, 0);
    run("quad read", 8'hEB, 1, 32'h8000_0001, 10, 2, 1, 0, 0, 6, 1, 0);
    run("status stop", 8'h05, 0, 0, 0, 0, 1, 0, 0, 1, 4, 1);
    run("flag status", 8'h70, 0, 0, 0, 0, 1, 0, 1, 2, 0, 0);
    run("program x1", 8'h02, 1, 32'h0000_0100, 0, 0, 2, 3, 0, 0, 0, 0);
    run("program x2", 8'hD2, 1, 32'h00FF_0000, 0, 1, 2, 2, 1, 0, 0, 0);
    run("program x4 full", 8'h12, 1, 32'h0ABC_DE00, 0, 2, 2, 256, 0, 0, 0, 0);
    reject(0);
    reject(257);
    run("wrdis after reject", 8'h04, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
    $finish;
  end
endmodule